// File: doc/BRIEF.md
# Compare Output Unit with Force Strobe

This block owns one waveform output pin of a timer channel. When the compare logic reports a match, or when software fires a force strobe, the block applies a pin action chosen by a 2-bit action mode: hold, toggle, drive low or drive high. A real match also emits a one-cycle pulse that sets the channel's interrupt flag. When the timer runs in clear-on-compare mode, a real match also emits a one-cycle request to clear the counter. A forced match moves the pin exactly as a real match would. It never raises the interrupt pulse and never requests a counter clear.

The force path only works while the timer is in a non-PWM mode. In PWM modes the pin belongs to the waveform generator outside this block, so this block holds its level and ignores both the force strobe and the pin action of real matches. The interrupt pulse of a real match still fires in PWM modes. The force input is a strobe and is not stored. The action mode sampled in the strobe cycle is the only one that matters.

The pin level is held by a two-state machine with states `PIN_LO` and `PIN_HI`. Each transition happens in the clock cycle after an applied event:
- `PIN_LO` goes to `PIN_HI` on toggle or set.
- `PIN_HI` goes to `PIN_LO` on toggle or clear.
- Every other combination stays in its current state, including hold mode and cycles with no applied event.

All three outputs are registered and change one clock after the inputs that cause them.

Top module: `compare_out_unit`

## Requirements
- R1: While reset is active and in the first cycle after it, `wave_o`, `flag_set_o` and `cnt_clr_o` are 0.
- R2: Action mode 2'b00 (hold) leaves `wave_o` unchanged after an applied event.
- R3: Action mode 2'b01 (toggle) inverts `wave_o` one cycle after an applied event.
- R4: Action mode 2'b10 (clear) drives `wave_o` to 0 one cycle after an applied event.
- R5: Action mode 2'b11 (set) drives `wave_o` to 1 one cycle after an applied event.
- R6: A force strobe with `pwm_mode_i` low applies the action mode present in that same cycle, one cycle later.
- R7: A force strobe with `pwm_mode_i` high has no effect on `wave_o`.
- R8: A force strobe alone never raises `flag_set_o`.
- R9: A force strobe alone never raises `cnt_clr_o`, even with `ctc_mode_i` high.
- R10: A real match raises `flag_set_o` for exactly the following cycle.
- R11: A real match raises `cnt_clr_o` in the following cycle only if `ctc_mode_i` is high in the match cycle.
- R12: A real match and a force strobe in the same cycle apply the action once, and the flag and clear outputs follow the real match.
- R13: A real match with `pwm_mode_i` high leaves `wave_o` unchanged but still raises `flag_set_o`.
- R14: With no match and no force, `wave_o` holds its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_hit_i | input | 1 | Real compare-match pulse |
| act_mode_i | input | 2 | Pin action: 00 hold, 01 toggle, 10 clear, 11 set |
| pwm_mode_i | input | 1 | Timer is in a PWM mode |
| force_i | input | 1 | Software force strobe |
| ctc_mode_i | input | 1 | Timer is in clear-on-compare mode |
| wave_o | output | 1 | Waveform output level |
| flag_set_o | output | 1 | One-cycle interrupt-flag set pulse |
| cnt_clr_o | output | 1 | One-cycle counter clear request |

## Verification
The bench builds the block with its default parameters. The action field is two bits wide and the pin resets low, so all four action codes can be reached from both pin states.

Directed cases cover the following:
- Every action from `PIN_LO` and from `PIN_HI`.
- Force in PWM and non-PWM modes.
- Force with clear-on-compare mode on.
- A match and a force landing in the same cycle.

Random traffic then mixes all five inputs freely. Back-to-back events and mode changes on the strobe cycle are covered there.

// File: rtl/cou_pkg.sv
package cou_pkg;

    localparam int ACT_W = 2;

    typedef enum logic [ACT_W-1:0] {
        ACT_HOLD   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } act_e;

    typedef enum logic {
        PIN_LO = 1'b0,
        PIN_HI = 1'b1
    } pin_state_e;

    typedef struct packed {
        logic apply;
        logic flag_req;
        logic clr_req;
    } evt_t;

endpackage

// File: rtl/cou_event_arb.sv
module cou_event_arb
    import cou_pkg::*;
(
    input  logic hit_i,
    input  logic force_i,
    input  logic pwm_i,
    input  logic ctc_i,
    output evt_t evt_o
);

    logic any_event;

    always_comb begin
        // a same-cycle match and force merge into a single pin event
        any_event      = hit_i | force_i;
        evt_o.apply    = any_event & ~pwm_i;
        // interrupt and clear only ever follow a real match
        evt_o.flag_req = hit_i;
        evt_o.clr_req  = hit_i & ctc_i;
    end

endmodule

// File: rtl/cou_pin_fsm.sv
module cou_pin_fsm
    import cou_pkg::*;
#(
    parameter logic RESET_LEVEL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             apply_i,
    input  logic [ACT_W-1:0] mode_i,
    output logic             level_o
);

    pin_state_e state_q;
    pin_state_e state_d;
    act_e       act;
    logic       seen_q;

    assign act = act_e'(mode_i);

    always_comb begin
        state_d = state_q;
        if (apply_i) begin
            unique case (state_q)
                PIN_LO: begin
                    if (act == ACT_TOGGLE || act == ACT_SET) state_d = PIN_HI;
                end
                PIN_HI: begin
                    if (act == ACT_TOGGLE || act == ACT_CLEAR) state_d = PIN_LO;
                end
                default: state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= pin_state_e'(RESET_LEVEL);
            seen_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            seen_q  <= 1'b1;
        end
    end

    always_comb begin
        level_o = (state_q == PIN_HI);
    end

    AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(apply_i) && $past(mode_i) == ACT_TOGGLE) |-> (level_o != $past(level_o))); // R3
    AST_CLEAR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(apply_i) && $past(mode_i) == ACT_CLEAR) |-> !level_o); // R4
    AST_SET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(apply_i) && $past(mode_i) == ACT_SET) |-> level_o); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && (!$past(apply_i) || $past(mode_i) == ACT_HOLD)) |-> $stable(level_o)); // R14

endmodule

// File: rtl/cou_strobe_reg.sv
module cou_strobe_reg #(
    parameter int N_STROBE = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_STROBE-1:0] req_i,
    output logic [N_STROBE-1:0] pulse_o
);

    for (genvar g = 0; g < N_STROBE; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pulse_o[g] <= 1'b0;
            else        pulse_o[g] <= req_i[g];
        end
    end

endmodule

// File: rtl/compare_out_unit.sv
module compare_out_unit
    import cou_pkg::*;
#(
    parameter logic RESET_LEVEL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_hit_i,
    input  logic [ACT_W-1:0] act_mode_i,
    input  logic             pwm_mode_i,
    input  logic             force_i,
    input  logic             ctc_mode_i,
    output logic             wave_o,
    output logic             flag_set_o,
    output logic             cnt_clr_o
);

    localparam int N_STROBE = 2;
    localparam int IDX_FLAG = 0;
    localparam int IDX_CLR  = 1;

    evt_t                evt;
    logic [N_STROBE-1:0] strobe_req;
    logic [N_STROBE-1:0] strobe_q;
    logic                seen_q;

    cou_event_arb u_arb (
        .hit_i   (cmp_hit_i),
        .force_i (force_i),
        .pwm_i   (pwm_mode_i),
        .ctc_i   (ctc_mode_i),
        .evt_o   (evt)
    );

    cou_pin_fsm #(.RESET_LEVEL(RESET_LEVEL)) u_pin (
        .clk     (clk),
        .rst_n   (rst_n),
        .apply_i (evt.apply),
        .mode_i  (act_mode_i),
        .level_o (wave_o)
    );

    always_comb begin
        strobe_req           = '0;
        strobe_req[IDX_FLAG] = evt.flag_req;
        strobe_req[IDX_CLR]  = evt.clr_req;
    end

    cou_strobe_reg #(.N_STROBE(N_STROBE)) u_strb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (strobe_req),
        .pulse_o (strobe_q)
    );

    assign flag_set_o = strobe_q[IDX_FLAG];
    assign cnt_clr_o  = strobe_q[IDX_CLR];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    AST_FLAG_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set_o |-> (seen_q && $past(cmp_hit_i))); // R8
    AST_CLR_NEEDS_HIT_CTC: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr_o |-> (seen_q && $past(cmp_hit_i) && $past(ctc_mode_i))); // R9
    AST_HIT_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(cmp_hit_i)) |-> flag_set_o); // R10
    AST_PWM_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(pwm_mode_i)) |-> $stable(wave_o)); // R7
    AST_RESET_QUIET: assert property (@(posedge clk)
        !seen_q |-> (!flag_set_o && !cnt_clr_o)); // R1

endmodule

// File: tb/sim_compare_out_unit.sv
module sim_compare_out_unit;

    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 400;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp_hit_i = 1'b0;
    logic [1:0] act_mode_i = 2'b00;
    logic       pwm_mode_i = 1'b0;
    logic       force_i = 1'b0;
    logic       ctc_mode_i = 1'b0;
    logic       wave_o, flag_set_o, cnt_clr_o;

    int n_chk = 0;
    int n_bad = 0;
    logic exp_wave = 1'b0, exp_flag = 1'b0, exp_clr = 1'b0;
    bit   done = 1'b0;

    compare_out_unit u0 (
        .clk(clk), .rst_n(rst_n), .cmp_hit_i(cmp_hit_i), .act_mode_i(act_mode_i),
        .pwm_mode_i(pwm_mode_i), .force_i(force_i), .ctc_mode_i(ctc_mode_i),
        .wave_o(wave_o), .flag_set_o(flag_set_o), .cnt_clr_o(cnt_clr_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic model_wave(logic cur, logic [1:0] mode, logic applied);
        if (!applied) return cur;
        case (mode)
            2'b01:   return ~cur;
            2'b10:   return 1'b0;
            2'b11:   return 1'b1;
            default: return cur;
        endcase
    endfunction

    task automatic check(string tag, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
        end
    endtask

    // called at a falling edge; outputs are checked at the next falling edge
    task automatic cyc(logic hit, logic [1:0] mode, logic pwm, logic frc, logic ctc, string tag);
        cmp_hit_i = hit; act_mode_i = mode; pwm_mode_i = pwm; force_i = frc; ctc_mode_i = ctc;
        exp_wave = model_wave(exp_wave, mode, (hit | frc) & ~pwm);
        exp_flag = hit;
        exp_clr  = hit & ctc;
        @(negedge clk);
        check(tag, "wave_o", wave_o, exp_wave);
        check(tag, "flag_set_o", flag_set_o, exp_flag);
        check(tag, "cnt_clr_o", cnt_clr_o, exp_clr);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R1", "wave_o in reset", wave_o, 1'b0);
        check("R1", "flag_set_o in reset", flag_set_o, 1'b0);
        check("R1", "cnt_clr_o in reset", cnt_clr_o, 1'b0);
        rst_n = 1'b1;
        cyc(0, 2'b00, 0, 0, 0, "R1");
        cyc(0, 2'b11, 0, 0, 1, "R14");           // no event: stays low
        cyc(1, 2'b00, 0, 0, 0, "R2");            // hold from PIN_LO, flag pulse
        cyc(1, 2'b01, 0, 0, 0, "R3");            // toggle -> high
        cyc(0, 2'b00, 0, 0, 0, "R10");           // flag lasts one cycle
        cyc(1, 2'b00, 0, 0, 1, "R2");            // hold from PIN_HI, clear request
        cyc(1, 2'b10, 0, 0, 0, "R4");            // clear -> low, no clr without ctc
        cyc(1, 2'b10, 0, 0, 1, "R11");           // clear while low, clr request
        cyc(1, 2'b11, 0, 0, 0, "R5");            // set -> high
        cyc(1, 2'b11, 0, 0, 0, "R5");            // set while high
        cyc(0, 2'b01, 0, 1, 0, "R6");            // forced toggle -> low
        cyc(0, 2'b11, 0, 1, 1, "R9");            // forced set in ctc: no clr
        cyc(0, 2'b10, 0, 1, 0, "R8");            // forced clear: no flag
        cyc(0, 2'b11, 1, 1, 0, "R7");            // force in pwm ignored
        cyc(0, 2'b01, 1, 1, 1, "R7");
        cyc(1, 2'b11, 1, 0, 0, "R13");           // real match in pwm: pin held, flag
        cyc(1, 2'b01, 0, 1, 1, "R12");           // merged: one toggle -> high
        cyc(1, 2'b01, 0, 1, 0, "R12");           // merged: one toggle -> low
        cyc(0, 2'b01, 0, 1, 0, "R6");            // back-to-back forces
        cyc(0, 2'b01, 0, 1, 0, "R6");
        for (int i = 0; i < N_RAND; i++) begin
            logic [5:0] r;
            r = 6'($urandom);
            cyc(r[0] & r[1], r[3:2], ($urandom % 4) == 0, r[4], r[5], "R14");
        end
        cyc(0, 2'b00, 0, 0, 0, "R14");
        finish_run();
    end

endmodule